// File: doc/BRIEF.md
# Pending Message-Interrupt Winner Scanner

This block keeps track of the most urgent pending message-signalled interrupt for one processor. The pending state lives in a bitmap in external memory, one bit per interrupt ID, and each interrupt has a one-byte configuration entry in a second table. The block reaches both tables through a byte-wide read port with a request/valid handshake. It reports the winning ID, its effective priority and a flag that says whether any winner exists.

Software or a neighbouring block sends it three commands. A full rescan walks the whole pending bitmap. A check compares one newly pending interrupt against the current winner with a single configuration read. A clear notification names an interrupt that has stopped pending, and it forces a rescan only when that interrupt is the current winner. Between commands the winner is held. While the block is disabled it does nothing and reports no winner. When it is enabled again it runs a full rescan by itself.

Top module: `lpi_best_finder`

## Requirements
- R1: After reset, busy, win_valid and rd_req are low, and win_prio is 0xFF.
- R2: While enable is low, no read is issued, busy stays low and win_valid is low. A cleared enable drops win_valid in the next cycle, and commands given while disabled have no effect.
- R3: A rising edge on enable starts a full rescan without any command, so busy is high in the cycle after the edge.
- R4: A full rescan first sets the held priority to 0xFF and clears win_valid. It then reads pending bytes at pending base + byte index, from byte 8192/8 through the last byte of a 2^(eff+1)-ID bitmap. Within each byte it takes bit 0 (ID byte*8) first. It issues one configuration read per set bit, so one scan makes exactly (byte count + set bits) reads. When 2^(eff+1) is at most 8192, no read is made and no winner results.
- R5: eff is the smaller of the idbits input and MAX_IDBITS (15 by default).
- R6: The configuration byte of ID N is read at configuration base + (N − 8192). Its bit 0 is the enable, and an entry with bit 0 clear never becomes the winner. The reported ID is never below 8192.
- R7: The priority field is configuration bits 7:2 with bits 1:0 zero. With dis_sec high that field is the priority. With dis_sec low the priority is the field shifted right by one, with bit 7 set.
- R8: A candidate replaces the held winner when its priority is numerically lower, or when the priorities are equal and its ID is less than or equal to the held ID.
- R9: A check command with an ID from 8192 to 2^(eff+1)−1 makes exactly one configuration read and applies the R8 rule. IDs outside that range are ignored and cause no read.
- R10: A clear command naming the current valid winner starts a full rescan. A clear for any other ID causes no read and leaves the result unchanged.
- R11: Address bits below bit 12 of both base inputs are ignored.
- R12: busy is high from the cycle after a command is accepted until the work ends. Commands that arrive while busy are dropped. A read request holds its address until rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Scanning allowed; a rising edge starts a rescan |
| dis_sec | input | 1 | Security disabled: priority is used unshifted |
| idbits | input | 5 | Programmed ID-width field |
| pend_base | input | 32 | Pending bitmap base address |
| cfg_base | input | 32 | Configuration table base address |
| cmd_rescan | input | 1 | Start a full rescan |
| cmd_check | input | 1 | Compare the one interrupt cmd_id against the winner |
| cmd_clear | input | 1 | cmd_id stopped pending |
| cmd_id | input | 16 | Interrupt ID for check and clear |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_addr | output | 32 | Byte address of the read |
| rd_valid | input | 1 | Read data is present this cycle |
| rd_data | input | 8 | Read data byte |
| busy | output | 1 | A scan or a check is in progress |
| win_valid | output | 1 | A winner exists |
| win_id | output | 16 | Winning interrupt ID |
| win_prio | output | 8 | Effective priority of the winner |

## Verification
The properties assume that the memory raises rd_valid only while rd_req is high, and that the bases, idbits and dis_sec stay steady while busy is high. The address-hold property compares rd_addr across cycles and depends on both of these. The bench memory answers every request one cycle later and only while rd_req is asserted. The stimulus changes bases, security mode and ID width only at idle points. Enable is lowered only when the block is idle, so no request is ever abandoned halfway.

// File: rtl/lpi_scan_pkg.sv
package lpi_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_BITS,
        ST_CFG
    } scan_st_e;

    localparam logic [7:0] PRIO_NONE  = 8'hFF;
    localparam logic [7:0] PRIO_FIELD = 8'hFC;
    localparam logic [7:0] PRIO_TOP   = 8'h80;

endpackage

// File: rtl/lpi_low_bit.sv
module lpi_low_bit #(
    parameter int W = 8
) (
    input  logic [W-1:0]         vec,
    output logic [$clog2(W)-1:0] idx
);
    localparam int IW = $clog2(W);

    // lowest set bit wins: scan from the top so the last hit is the lowest
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/lpi_cfg_xlate.sv
module lpi_cfg_xlate
    import lpi_scan_pkg::*;
(
    input  logic [7:0] cfg_byte,
    input  logic       sec_off,
    output logic       enabled,
    output logic [7:0] prio
);
    logic [7:0] field;

    always_comb begin
        field   = cfg_byte & PRIO_FIELD;
        enabled = cfg_byte[0];
        prio    = sec_off ? field : (PRIO_TOP | (field >> 1));
    end
endmodule

// File: rtl/lpi_rank_cmp.sv
module lpi_rank_cmp #(
    parameter int ID_W = 16
) (
    input  logic [7:0]      cand_prio,
    input  logic [ID_W-1:0] cand_id,
    input  logic [7:0]      best_prio,
    input  logic [ID_W-1:0] best_id,
    output logic            take
);
    always_comb begin
        take = (cand_prio < best_prio) ||
               ((cand_prio == best_prio) && (cand_id <= best_id));
    end
endmodule

// File: rtl/lpi_best_finder.sv
module lpi_best_finder
    import lpi_scan_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_IDBITS = 15,
    parameter int IDB_W      = 5,
    parameter int FIRST_ID   = 8192,
    parameter int BASE_LSB   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  dis_sec,
    input  logic [IDB_W-1:0]      idbits,
    input  logic [ADDR_W-1:0]     pend_base,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic                  cmd_rescan,
    input  logic                  cmd_check,
    input  logic                  cmd_clear,
    input  logic [MAX_IDBITS:0]   cmd_id,
    output logic                  rd_req,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_valid,
    input  logic [7:0]            rd_data,
    output logic                  busy,
    output logic                  win_valid,
    output logic [MAX_IDBITS:0]   win_id,
    output logic [7:0]            win_prio
);
    localparam int ID_W   = MAX_IDBITS + 1;
    localparam int BYTE_W = ID_W - 3;
    localparam int SPAN_W = ID_W + 1;
    localparam logic [ID_W-1:0]   FIRST_ID_V = ID_W'(FIRST_ID);
    localparam logic [BYTE_W-1:0] FIRST_BYTE = BYTE_W'(FIRST_ID / 8);
    localparam logic [SPAN_W-1:0] FIRST_SPAN = SPAN_W'(FIRST_ID / 8);
    localparam logic [ADDR_W-1:0] BASE_MASK  =
        ~((ADDR_W'(1) << BASE_LSB) - ADDR_W'(1));

    typedef struct packed {
        scan_st_e          st;
        logic [BYTE_W-1:0] byte_ix;
        logic [7:0]        bits;
        logic [ID_W-1:0]   cur_id;
        logic              single;
        logic [7:0]        best_prio;
        logic [ID_W-1:0]   best_id;
        logic              best_ok;
        logic              en_seen;
    } scan_s;

    scan_s s_d, s_q;

    logic [IDB_W-1:0]  eff_bits;
    logic [SPAN_W-1:0] span, span_bytes;
    logic [BYTE_W-1:0] last_byte;
    logic              range_empty, id_ok;
    logic [ADDR_W-1:0] pbase_m, cbase_m;
    logic [2:0]        pick;
    logic              cand_en, cand_take;
    logic [7:0]        cand_prio;
    logic              idle, hit_winner, go_full, go_one;

    lpi_low_bit #(.W(8)) u_pick (
        .vec (s_q.bits),
        .idx (pick)
    );

    lpi_cfg_xlate u_xlate (
        .cfg_byte (rd_data),
        .sec_off  (dis_sec),
        .enabled  (cand_en),
        .prio     (cand_prio)
    );

    lpi_rank_cmp #(.ID_W(ID_W)) u_rank (
        .cand_prio (cand_prio),
        .cand_id   (s_q.cur_id),
        .best_prio (s_q.best_prio),
        .best_id   (s_q.best_id),
        .take      (cand_take)
    );

    // table geometry from the clamped ID width
    always_comb begin
        eff_bits    = (idbits > IDB_W'(MAX_IDBITS)) ? IDB_W'(MAX_IDBITS) : idbits;
        span        = SPAN_W'(1) << (eff_bits + IDB_W'(1));
        span_bytes  = span >> 3;
        range_empty = (span_bytes <= FIRST_SPAN);
        last_byte   = BYTE_W'(span_bytes - SPAN_W'(1));
        id_ok       = ({1'b0, cmd_id} >= SPAN_W'(FIRST_ID)) && ({1'b0, cmd_id} < span);
        pbase_m     = pend_base & BASE_MASK;
        cbase_m     = cfg_base & BASE_MASK;
    end

    always_comb begin
        s_d         = s_q;
        s_d.en_seen = enable;
        idle        = (s_q.st == ST_IDLE);
        hit_winner  = cmd_clear && s_q.best_ok && (cmd_id == s_q.best_id);
        go_full     = enable && (!s_q.en_seen || (idle && (cmd_rescan || hit_winner)));
        go_one      = enable && idle && cmd_check && id_ok && !go_full;

        if (!enable) begin
            s_d.st        = ST_IDLE;
            s_d.best_prio = PRIO_NONE;
            s_d.best_id   = '1;
            s_d.best_ok   = 1'b0;
        end else if (go_full) begin
            s_d.best_prio = PRIO_NONE;
            s_d.best_id   = '1;
            s_d.best_ok   = 1'b0;
            s_d.byte_ix   = FIRST_BYTE;
            s_d.st        = range_empty ? ST_IDLE : ST_PEND;
        end else if (go_one) begin
            s_d.cur_id = cmd_id;
            s_d.single = 1'b1;
            s_d.st     = ST_CFG;
        end else begin
            case (s_q.st)
                ST_PEND: begin
                    if (rd_valid) begin
                        s_d.bits = rd_data;
                        s_d.st   = ST_BITS;
                    end
                end
                ST_BITS: begin
                    if (s_q.bits == 8'h00) begin
                        if (s_q.byte_ix == last_byte) begin
                            s_d.st = ST_IDLE;
                        end else begin
                            s_d.byte_ix = s_q.byte_ix + BYTE_W'(1);
                            s_d.st      = ST_PEND;
                        end
                    end else begin
                        s_d.cur_id = {s_q.byte_ix, pick};
                        s_d.bits   = s_q.bits & ~(8'h01 << pick);
                        s_d.single = 1'b0;
                        s_d.st     = ST_CFG;
                    end
                end
                ST_CFG: begin
                    if (rd_valid) begin
                        if (cand_en && cand_take) begin
                            s_d.best_prio = cand_prio;
                            s_d.best_id   = s_q.cur_id;
                            s_d.best_ok   = 1'b1;
                        end
                        s_d.st = s_q.single ? ST_IDLE : ST_BITS;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, byte_ix: '0, bits: '0, cur_id: '0,
                     single: 1'b0, best_prio: PRIO_NONE, best_id: '1,
                     best_ok: 1'b0, en_seen: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_req    = (s_q.st == ST_PEND) || (s_q.st == ST_CFG);
        rd_addr   = (s_q.st == ST_PEND) ? (pbase_m + ADDR_W'(s_q.byte_ix))
                                        : (cbase_m + ADDR_W'(s_q.cur_id - FIRST_ID_V));
        busy      = (s_q.st != ST_IDLE);
        win_valid = s_q.best_ok;
        win_id    = s_q.best_id;
        win_prio  = s_q.best_prio;
    end

    p_quiet_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !win_valid));

    p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid && enable) |=> (rd_req && $stable(rd_addr)));

    p_id_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_id >= FIRST_ID_V));

    p_prio_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> !win_prio[0]);

    p_none_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (win_prio == PRIO_NONE));

endmodule

// File: tb/sim_lpi_best_finder.sv
module sim_lpi_best_finder;
    localparam int CLK_P = 10;
    localparam logic [31:0] PB = 32'h0001_0000;
    localparam logic [31:0] CB = 32'h0004_0000;

    // id_a, cfg_a, id_b, cfg_b, dis_sec, exp_valid, exp_id, exp_prio
    localparam logic [73:0] VEC [8] = '{
        {16'd8192,  8'h41, 16'd8200,  8'h81, 1'b1, 1'b1, 16'd8192,  8'h40},
        {16'd8192,  8'h41, 16'd8200,  8'h81, 1'b0, 1'b1, 16'd8192,  8'hA0},
        {16'd9000,  8'h21, 16'd8300,  8'h21, 1'b1, 1'b1, 16'd8300,  8'h20},
        {16'd8195,  8'h20, 16'd12000, 8'hF1, 1'b1, 1'b1, 16'd12000, 8'hF0},
        {16'd8194,  8'h10, 16'd8196,  8'h00, 1'b1, 1'b0, 16'd65535, 8'hFF},
        {16'd8197,  8'h31, 16'd8193,  8'h31, 1'b0, 1'b1, 16'd8193,  8'h98},
        {16'd16383, 8'h05, 16'd8192,  8'hFD, 1'b1, 1'b1, 16'd16383, 8'h04},
        {16'd8191,  8'h01, 16'd10000, 8'h61, 1'b1, 1'b1, 16'd10000, 8'h60}
    };

    logic        clk = 1'b0;
    logic        rst_n, enable, dis_sec;
    logic [4:0]  idbits;
    logic [31:0] pend_base, cfg_base;
    logic        cmd_rescan, cmd_check, cmd_clear;
    logic [15:0] cmd_id;
    logic        rd_req, rd_valid, busy, win_valid;
    logic [31:0] rd_addr;
    logic [7:0]  rd_data, win_prio;
    logic [15:0] win_id;

    logic [7:0] mem [int unsigned];
    int n_chk = 0;
    int n_fail = 0;
    int rd_total = 0;
    int base;

    lpi_best_finder u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dis_sec(dis_sec),
        .idbits(idbits), .pend_base(pend_base), .cfg_base(cfg_base),
        .cmd_rescan(cmd_rescan), .cmd_check(cmd_check), .cmd_clear(cmd_clear),
        .cmd_id(cmd_id), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio)
    );

    always #(CLK_P / 2) clk = ~clk;

    function automatic logic [7:0] rd_mem(input logic [31:0] a);
        int unsigned k = a;
        return mem.exists(k) ? mem[k] : 8'h00;
    endfunction

    // memory model: answers one cycle after a request
    initial begin
        rd_valid = 1'b0;
        rd_data  = 8'h00;
        forever begin
            @(negedge clk);
            if (rd_req && !rd_valid) begin
                rd_valid = 1'b1;
                rd_data  = rd_mem(rd_addr);
                rd_total++;
            end else begin
                rd_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL R12 watchdog act=busy exp=idle");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic set_pend(input int id);
        int unsigned a = PB + id / 8;
        mem[a] = rd_mem(a) | (8'h01 << (id % 8));
    endtask

    task automatic clr_pend(input int id);
        int unsigned a = PB + id / 8;
        mem[a] = rd_mem(a) & ~(8'h01 << (id % 8));
    endtask

    task automatic set_cfg(input int id, input logic [7:0] v);
        mem[CB + id - 8192] = v;
    endtask

    task automatic pulse(input int kind, input logic [15:0] id);
        @(negedge clk);
        cmd_id     = id;
        cmd_rescan = (kind == 0);
        cmd_check  = (kind == 1);
        cmd_clear  = (kind == 2);
        @(negedge clk);
        cmd_rescan = 1'b0;
        cmd_check  = 1'b0;
        cmd_clear  = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 30000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 30000) check("R12 scan end", 32'(busy), 32'd0);
    endtask

    task automatic expect_win(input string tag, input logic [15:0] id, input logic [7:0] p);
        check({tag, " valid"}, 32'(win_valid), 32'd1);
        check({tag, " id"}, 32'(win_id), 32'(id));
        check({tag, " prio"}, 32'(win_prio), 32'(p));
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b0; dis_sec = 1'b1; idbits = 5'd13;
        pend_base = PB; cfg_base = CB;
        cmd_rescan = 1'b0; cmd_check = 1'b0; cmd_clear = 1'b0; cmd_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 valid", 32'(win_valid), 32'd0);
        check("R1 req", 32'(rd_req), 32'd0);
        check("R1 prio", 32'(win_prio), 32'hFF);

        enable = 1'b1;
        wait_idle();

        // vector table: two pending entries per scan
        for (int v = 0; v < 8; v++) begin
            logic [73:0] e;
            int exp_rd;
            e = VEC[v];
            mem.delete();
            set_pend(int'(e[73:58])); set_cfg(int'(e[73:58]), e[57:50]);
            set_pend(int'(e[49:34])); set_cfg(int'(e[49:34]), e[33:26]);
            dis_sec = e[25];
            exp_rd = 1024 + int'(e[73:58] >= 16'd8192) + int'(e[49:34] >= 16'd8192);
            base = rd_total;
            pulse(0, '0);
            wait_idle();
            check("R6 vector valid", 32'(win_valid), 32'(e[24]));
            if (e[24]) check("R8 vector id", 32'(win_id), 32'(e[23:8]));
            check("R7 vector prio", 32'(win_prio), 32'(e[7:0]));
            check("R4 vector reads", 32'(rd_total - base), 32'(exp_rd));
        end

        // single checks against winner 10000 / 0x60
        set_pend(9000); set_cfg(9000, 8'h51);
        base = rd_total; pulse(1, 16'd9000); wait_idle();
        expect_win("R9 check better", 16'd9000, 8'h50);
        check("R9 one read", 32'(rd_total - base), 32'd1);

        set_pend(8500); set_cfg(8500, 8'h71);
        pulse(1, 16'd8500); wait_idle();
        expect_win("R8 worse kept", 16'd9000, 8'h50);

        set_pend(9500); set_cfg(9500, 8'h51);
        pulse(1, 16'd9500); wait_idle();
        expect_win("R8 tie higher id", 16'd9000, 8'h50);

        set_pend(8800); set_cfg(8800, 8'h51);
        pulse(1, 16'd8800); wait_idle();
        expect_win("R8 tie lower id", 16'd8800, 8'h50);

        set_pend(8400); set_cfg(8400, 8'h40);
        pulse(1, 16'd8400); wait_idle();
        expect_win("R6 disabled entry", 16'd8800, 8'h50);

        set_cfg(16384, 8'h01);
        base = rd_total; pulse(1, 16'd16384); wait_idle();
        check("R9 out of range reads", 32'(rd_total - base), 32'd0);
        expect_win("R9 out of range", 16'd8800, 8'h50);

        base = rd_total; pulse(2, 16'd9500); wait_idle();
        check("R10 other clear reads", 32'(rd_total - base), 32'd0);
        expect_win("R10 other clear", 16'd8800, 8'h50);

        clr_pend(8800);
        base = rd_total; pulse(2, 16'd8800); wait_idle();
        expect_win("R10 winner clear", 16'd9000, 8'h50);
        check("R10 rescan reads", 32'(rd_total - base), 32'd1029);

        // a check sent while busy is dropped
        base = rd_total;
        pulse(0, '0);
        check("R12 busy during scan", 32'(busy), 32'd1);
        pulse(1, 16'd8800);
        wait_idle();
        expect_win("R12 busy drop", 16'd9000, 8'h50);
        check("R12 busy drop reads", 32'(rd_total - base), 32'd1029);

        pend_base = PB | 32'h0000_0ABC;
        cfg_base  = CB | 32'h0000_0123;
        pulse(0, '0); wait_idle();
        expect_win("R11 low bits ignored", 16'd9000, 8'h50);
        pend_base = PB; cfg_base = CB;

        // ID width clamp and empty range
        mem.delete();
        set_pend(65535); set_cfg(65535, 8'h09);
        idbits = 5'd20;
        base = rd_total; pulse(0, '0); wait_idle();
        expect_win("R5 clamp", 16'd65535, 8'h08);
        check("R5 clamp reads", 32'(rd_total - base), 32'd7169);

        idbits = 5'd12;
        base = rd_total; pulse(0, '0); wait_idle();
        check("R4 empty valid", 32'(win_valid), 32'd0);
        check("R4 empty prio", 32'(win_prio), 32'hFF);
        check("R4 empty reads", 32'(rd_total - base), 32'd0);

        // disable and re-enable
        idbits = 5'd13;
        set_pend(8192); set_cfg(8192, 8'h11);
        pulse(0, '0); wait_idle();
        expect_win("R4 before disable", 16'd8192, 8'h10);
        enable = 1'b0;
        @(negedge clk);
        check("R2 valid drops", 32'(win_valid), 32'd0);
        base = rd_total;
        pulse(0, '0);
        check("R2 no busy", 32'(busy), 32'd0);
        repeat (4) @(negedge clk);
        check("R2 no reads", 32'(rd_total - base), 32'd0);
        check("R2 still no winner", 32'(win_valid), 32'd0);

        enable = 1'b1;
        @(negedge clk);
        check("R3 busy after rise", 32'(busy), 32'd1);
        wait_idle();
        expect_win("R3 auto rescan", 16'd8192, 8'h10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule